// File: doc/BRIEF.md
# MDIO Management Master with Register Access

This block lets software run single Clause 22 management transactions on an MDIO bus. It presents two 32-bit word registers on a simple register bus: a control word and a data word. For a write, software first loads the 16-bit value into the data word. It then writes the control word with the go bit and the write flag set. For a read, software writes the control word with the go bit set and the write flag clear. The block then shifts out one full management frame on MDC/MDIO, and the go bit reads back as 1 until that frame has finished.

The MDC rate comes from the system clock. A three-bit range code picks the divisor, which keeps MDC at or below 2.5 MHz. When a read completes, the 16 bits sampled from the PHY replace the data word. They are valid once the go bit reads 0.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The control word is at byte offset 0x10 and the data word at byte offset 0x14 (word index = bus_addr[7:2]). `bus_rdata` shows the addressed word on the cycle after a `bus_rd_en` strobe. Any other offset reads 0. The control word reads back as {16'b0, phy[15:11], reg[10:6], 1'b0, range[4:2], write[1], busy[0]}. The data word reads back zero-extended from 16 bits.
- R2: A control write with bit 0 set, made while idle, starts a frame, and bit 0 reads 1 on the first read after that write. Bit 0 returns to 0 only after the frame ends. A control write with bit 0 clear stores the fields and starts no frame: MDC stays low and bit 0 reads 0.
- R3: With bit 1 set, the frame is 64 bits, sent in order: 32 ones, then 01, then opcode 01, then the 5-bit PHY address MSB first, then the 5-bit register number MSB first, then turnaround 10, then the 16 data bits MSB first. MDIO is driven (`mdio_oe`=1) for all 64 bits.
- R4: With bit 1 clear, the opcode is 10. `mdio_oe` is 1 for the first 46 bits and 0 from the turnaround onward. The last 16 bits are sampled on the rising edge of MDC, MSB first. The result becomes the data word when bit 0 clears.
- R5: The MDC period equals the divisor for range code 0..5: 42, 62, 16, 26, 102 and 124 system clocks. Codes 6 and 7 use 42.
- R6: MDC is low while no frame is in progress. While MDIO is driven, `mdio_out` changes only in the cycle where MDC falls.
- R7: A control write that arrives while bit 0 is 1 is ignored. The fields read back unchanged, and the running frame is unaffected.
- R8: A data write while a read frame is in progress is ignored, and the PHY value still lands in the data word. A data write at any other time is taken. A data write during a write frame does not alter the data bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr_en | input | 1 | Write strobe, one cycle per access |
| bus_rd_en | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd_en` |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO value seen on the bus |

## Verification
Read data appears one cycle after the read strobe, so the bench raises the strobe on a falling clock edge and samples on the next falling edge. Frame contents are captured 1 ns after each rising MDC edge, because MDIO only moves on falling edges. The PHY model drives read bits right after each falling MDC edge, well before the next rising edge. The MDC period is measured in system clocks between the first two rising edges of each frame. Read results, and the effect of writes ignored while busy, are checked only after polling shows bit 0 clear, which is the point where the data word is defined to be valid.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    localparam int DIV_R0  = 42;
    localparam int DIV_R1  = 62;
    localparam int DIV_R2  = 16;
    localparam int DIV_R3  = 26;
    localparam int DIV_R4  = 102;
    localparam int DIV_R5  = 124;
    localparam int DIV_MAX = 124;
    localparam int HALF_W  = $clog2(DIV_MAX / 2 + 1);

    localparam int CTL_BUSY = 0;
    localparam int CTL_WR   = 1;
    localparam int CTL_RNG  = 2;
    localparam int CTL_REG  = 6;
    localparam int CTL_PHY  = 11;

    typedef logic [HALF_W-1:0] half_t;

    // Clocks per MDC half period for a range code; unused codes fall back to code 0.
    function automatic half_t half_for_code(input logic [2:0] code);
        case (code)
            3'd1:    return half_t'(DIV_R1 / 2);
            3'd2:    return half_t'(DIV_R2 / 2);
            3'd3:    return half_t'(DIV_R3 / 2);
            3'd4:    return half_t'(DIV_R4 / 2);
            3'd5:    return half_t'(DIV_R5 / 2);
            default: return half_t'(DIV_R0 / 2);
        endcase
    endfunction
endpackage

// File: rtl/mdio_mdc_divsel.sv
module mdio_mdc_divsel
    import mdio_mgmt_pkg::*;
(
    input  logic [2:0] range_code,
    output half_t      half_clks
);
    always_comb begin
        half_clks = half_for_code(range_code);
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_read,
    input  logic [4:0]        phy_addr,
    input  logic [4:0]        reg_num,
    input  logic [DATA_W-1:0] wdata,
    input  half_t             half_clks,
    input  logic              mdio_in,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    localparam int FRAME_BITS = PRE_LEN + 16 + DATA_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] TA_POS   = IDX_W'(PRE_LEN + 14);
    localparam logic [IDX_W-1:0] DATA_POS = IDX_W'(PRE_LEN + 16);
    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic                  active;
        logic                  is_read;
        logic                  phase;
        half_t                 half_cnt;
        logic [IDX_W-1:0]      bit_idx;
        logic [FRAME_BITS-1:0] shreg;
        logic [DATA_W-1:0]     rd;
        logic                  oe;
        logic                  done;
    } eng_s;

    eng_s s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.active) begin
            if (start) begin
                s_d.active   = 1'b1;
                s_d.is_read  = is_read;
                s_d.phase    = 1'b0;
                s_d.half_cnt = '0;
                s_d.bit_idx  = '0;
                s_d.shreg    = {{PRE_LEN{1'b1}}, 2'b01,
                                (is_read ? 2'b10 : 2'b01),
                                phy_addr, reg_num,
                                (is_read ? 2'b00 : 2'b10),
                                (is_read ? {DATA_W{1'b0}} : wdata)};
            end
        end else if (s_q.half_cnt == half_clks - half_t'(1)) begin
            s_d.half_cnt = '0;
            if (!s_q.phase) begin
                // rising MDC edge: sample returned data
                s_d.phase = 1'b1;
                if (s_q.is_read && s_q.bit_idx >= DATA_POS)
                    s_d.rd = {s_q.rd[DATA_W-2:0], mdio_in};
            end else begin
                // falling MDC edge: advance to the next bit
                s_d.phase = 1'b0;
                if (s_q.bit_idx == LAST_POS) begin
                    s_d.active = 1'b0;
                    s_d.done   = 1'b1;
                end else begin
                    s_d.bit_idx = s_q.bit_idx + IDX_W'(1);
                    s_d.shreg   = {s_q.shreg[FRAME_BITS-2:0], 1'b0};
                end
            end
        end else begin
            s_d.half_cnt = s_q.half_cnt + half_t'(1);
        end
        s_d.oe = s_d.active && !(s_d.is_read && s_d.bit_idx >= TA_POS);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc      = s_q.phase;
    assign mdio_out = s_q.shreg[FRAME_BITS-1];
    assign mdio_oe  = s_q.oe;
    assign done     = s_q.done;
    assign rdata    = s_q.rd;

    // R4: the bus is never driven during the data bits of a read
    a_r4_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && s_q.is_read && s_q.bit_idx >= DATA_POS) |-> !mdio_oe);
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_mgmt_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int CTRL_OFS = 16,
    parameter int DATA_OFS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              eng_done,
    input  logic [DATA_W-1:0] eng_rdata,
    output logic              start,
    output logic              busy,
    output logic              is_read,
    output logic [4:0]        phy_addr,
    output logic [4:0]        reg_num,
    output logic [2:0]        range_code,
    output logic [DATA_W-1:0] data_word
);
    localparam logic [ADDR_W-3:0] CTRL_IDX = (ADDR_W-2)'(CTRL_OFS / 4);
    localparam logic [ADDR_W-3:0] DATA_IDX = (ADDR_W-2)'(DATA_OFS / 4);

    typedef struct packed {
        logic              busy;
        logic              wr;
        logic [2:0]        code;
        logic [4:0]        phy;
        logic [4:0]        regn;
        logic [DATA_W-1:0] data;
        logic              start;
        logic [31:0]       rdata;
    } regs_s;

    regs_s r_d, r_q;
    logic  hit_ctrl, hit_data;
    logic  unused_bits;

    assign hit_ctrl    = bus_addr[ADDR_W-1:2] == CTRL_IDX;
    assign hit_data    = bus_addr[ADDR_W-1:2] == DATA_IDX;
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:16]};

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        if (bus_wr_en && hit_ctrl && !r_q.busy) begin
            r_d.wr   = bus_wdata[CTL_WR];
            r_d.code = bus_wdata[CTL_RNG +: 3];
            r_d.regn = bus_wdata[CTL_REG +: 5];
            r_d.phy  = bus_wdata[CTL_PHY +: 5];
            if (bus_wdata[CTL_BUSY]) begin
                r_d.busy  = 1'b1;
                r_d.start = 1'b1;
            end
        end
        if (bus_wr_en && hit_data && !(r_q.busy && !r_q.wr))
            r_d.data = bus_wdata[DATA_W-1:0];
        if (eng_done) begin
            r_d.busy = 1'b0;
            if (!r_q.wr) r_d.data = eng_rdata;
        end
        if (bus_rd_en) begin
            if (hit_ctrl)
                r_d.rdata = {16'b0, r_q.phy, r_q.regn, 1'b0, r_q.code, r_q.wr, r_q.busy};
            else if (hit_data)
                r_d.rdata = {{(32-DATA_W){1'b0}}, r_q.data};
            else
                r_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata  = r_q.rdata;
    assign start      = r_q.start;
    assign busy       = r_q.busy;
    assign is_read    = !r_q.wr;
    assign phy_addr   = r_q.phy;
    assign reg_num    = r_q.regn;
    assign range_code = r_q.code;
    assign data_word  = r_q.data;

    // R2: the go bit clears only when the engine reports the frame done
    a_r2_busy_ends_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.busy) |-> $past(eng_done));
    // R7: command fields hold while a frame is in progress
    a_r7_ctrl_held: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.busy |=> ($stable(r_q.phy) && $stable(r_q.regn) && $stable(r_q.code) && $stable(r_q.wr)));
    // R8: data word is untouched during a read until its result arrives
    a_r8_data_held_read: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.busy && !r_q.wr && !eng_done) |=> $stable(r_q.data));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);
    localparam int DATA_W = 16;

    logic              start, busy, is_read, eng_done;
    logic [4:0]        phy_addr, reg_num;
    logic [2:0]        range_code;
    logic [DATA_W-1:0] data_word, eng_rdata;
    half_t             half_clks;

    mdio_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_done(eng_done), .eng_rdata(eng_rdata),
        .start(start), .busy(busy), .is_read(is_read),
        .phy_addr(phy_addr), .reg_num(reg_num), .range_code(range_code),
        .data_word(data_word)
    );

    mdio_mdc_divsel divsel_i (
        .range_code(range_code), .half_clks(half_clks)
    );

    mdio_frame_engine #(.PRE_LEN(PRE_LEN), .DATA_W(DATA_W)) engine_i (
        .clk(clk), .rst_n(rst_n),
        .start(start), .is_read(is_read),
        .phy_addr(phy_addr), .reg_num(reg_num), .wdata(data_word),
        .half_clks(half_clks), .mdio_in(mdio_in),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .done(eng_done), .rdata(eng_rdata)
    );

    // R6: MDC rests low outside a frame
    a_r6_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);
    // R6: a driven MDIO only moves together with a falling MDC
    a_r6_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && !$fell(mdc)) |-> $stable(mdio_out));
endmodule

// File: tb/mdio_mgmt_master_tb_top.sv
module mdio_mgmt_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int pcnt = 0;
    int t0 = 0, t1 = 0;
    int viol = 0;
    logic [63:0] cap = '0, oecap = '0;
    logic [15:0] phy_rd = '0;
    logic prev_oe = 1'b0, prev_out = 1'b0, prev_mdc = 1'b0;

    always #4 clk = ~clk;

    mdio_mgmt_master dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // PHY model: capture on rising MDC, drive read bits after falling MDC
    always @(posedge mdc) begin
        #1;
        cap   = {cap[62:0], mdio_out};
        oecap = {oecap[62:0], mdio_oe};
        if (pcnt == 0) t0 = cyc;
        if (pcnt == 1) t1 = cyc;
        pcnt = pcnt + 1;
    end
    always @(negedge mdc) begin
        mdio_in = (pcnt >= 48 && pcnt <= 63) ? phy_rd[63-pcnt] : 1'b1;
    end

    // R6 monitor: driven output changing without a falling MDC
    always @(posedge clk) begin
        #1;
        if (rst_n && mdio_oe && prev_oe && (mdio_out != prev_out) && !(prev_mdc && !mdc))
            viol = viol + 1;
        prev_oe  = mdio_oe;
        prev_out = mdio_out;
        prev_mdc = mdc;
    end

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        errors = errors + 1;
        $display("FAIL watchdog: run did not complete (actual timeout, expected completion)");
        report();
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    function automatic int exp_div(input int code);
        case (code)
            1: return 62;
            2: return 16;
            3: return 26;
            4: return 102;
            5: return 124;
            default: return 42;
        endcase
    endfunction

    function automatic logic [31:0] ctl(input int code, input logic wr,
                                        input logic [4:0] phy, input logic [4:0] rg, input logic go);
        return {16'b0, phy, rg, 1'b0, 3'(code), wr, go};
    endfunction

    function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, d};
    endfunction

    task automatic wait_idle();
        logic [31:0] v;
        int n = 0;
        do begin
            bus_read(8'h10, v);
            n = n + 1;
        end while (v[0] && n < 20000);
    endtask

    task automatic run_frame(input int code, input logic wr, input logic [4:0] phy,
                             input logic [4:0] rg, input logic [15:0] d, input logic [15:0] rv);
        logic [31:0] v;
        pcnt = 0; phy_rd = rv;
        if (wr) bus_write(8'h14, {16'b0, d});
        bus_write(8'h10, ctl(code, wr, phy, rg, 1'b1));
        bus_read(8'h10, v);
        chk("R2 busy set after go", 64'(v[0]), 64'd1);
        wait_idle();
        chk("R2 frame length", 64'(pcnt), 64'd64);
        chk("R5 MDC period", 64'(t1 - t0), 64'(exp_div(code)));
        chk("R6 MDC low after frame", 64'(mdc), 64'd0);
        if (wr) begin
            chk("R3 write frame bits", cap, exp_frame(1'b1, phy, rg, d));
            chk("R3 oe whole frame", oecap, 64'hFFFF_FFFF_FFFF_FFFF);
        end else begin
            chk("R4 read header bits", 64'(cap[63:18]), 64'(exp_frame(1'b0, phy, rg, 16'h0) >> 18));
            chk("R4 oe released at turnaround", oecap, 64'hFFFF_FFFF_FFFC_0000);
            bus_read(8'h14, v);
            chk("R4 read data returned", 64'(v), 64'(rv));
        end
        bus_read(8'h10, v);
        chk("R1 ctrl readback", 64'(v), 64'(ctl(code, wr, phy, rg, 1'b0)));
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        chk("R6 reset mdc", 64'(mdc), 64'd0);
        chk("R6 reset oe", 64'(mdio_oe), 64'd0);
        bus_read(8'h10, v); chk("R1 reset ctrl", 64'(v), 64'd0);
        bus_read(8'h14, v); chk("R1 reset data", 64'(v), 64'd0);

        // R8 idle data write taken, upper bits drop; R1 unmapped offsets
        bus_write(8'h14, 32'hDEAD_BEEF);
        bus_read(8'h14, v); chk("R8 idle data write", 64'(v), 64'h0000_BEEF);
        bus_read(8'h18, v); chk("R1 unmapped 0x18", 64'(v), 64'd0);
        bus_read(8'h00, v); chk("R1 unmapped 0x00", 64'(v), 64'd0);

        // R2 go clear: fields stored, no frame
        pcnt = 0;
        bus_write(8'h10, ctl(2, 1'b1, 5'h15, 5'h0A, 1'b0));
        repeat (200) @(negedge clk);
        bus_read(8'h10, v); chk("R2 no go stores fields", 64'(v), 64'(ctl(2, 1'b1, 5'h15, 5'h0A, 1'b0)));
        chk("R2 no go no MDC edges", 64'(pcnt), 64'd0);

        // R3 R5 write sweep over every range code
        for (int c = 0; c < 8; c++)
            run_frame(c, 1'b1, 5'(c * 3 + 1), 5'(31 - c), 16'hA5C3 ^ 16'(c * 16'h1111), 16'h0);

        // R4 read sweep
        run_frame(2, 1'b0, 5'h1F, 5'h00, 16'h0, 16'hFFFF);
        run_frame(2, 1'b0, 5'h00, 5'h1F, 16'h0, 16'h0001);
        run_frame(3, 1'b0, 5'h0B, 5'h14, 16'h0, 16'h8000);
        run_frame(2, 1'b0, 5'h12, 5'h09, 16'h0, 16'h5A5A);

        // R7 R8: writes during a read frame are ignored
        pcnt = 0; phy_rd = 16'hC3A5;
        bus_write(8'h10, ctl(2, 1'b0, 5'h07, 5'h03, 1'b1));
        repeat (40) @(negedge clk);
        bus_write(8'h10, ctl(5, 1'b1, 5'h1E, 5'h11, 1'b1));
        bus_write(8'h14, 32'h0000_1234);
        wait_idle();
        bus_read(8'h10, v); chk("R7 ctrl write while busy ignored", 64'(v), 64'(ctl(2, 1'b0, 5'h07, 5'h03, 1'b0)));
        chk("R7 frame header kept", 64'(cap[63:18]), 64'(exp_frame(1'b0, 5'h07, 5'h03, 16'h0) >> 18));
        chk("R7 period kept", 64'(t1 - t0), 64'd16);
        bus_read(8'h14, v); chk("R8 data write during read ignored", 64'(v), 64'h0000_C3A5);

        // R8: data write during a write frame is taken, sent bits unchanged
        pcnt = 0;
        bus_write(8'h14, 32'h0000_6E21);
        bus_write(8'h10, ctl(2, 1'b1, 5'h09, 5'h1F, 1'b1));
        repeat (40) @(negedge clk);
        bus_write(8'h14, 32'h0000_0F0F);
        bus_read(8'h14, v); chk("R8 data write during write frame", 64'(v), 64'h0000_0F0F);
        wait_idle();
        chk("R8 sent data unchanged", cap, exp_frame(1'b1, 5'h09, 5'h1F, 16'h6E21));

        chk("R6 output moved only on falling MDC", 64'(viol), 64'd0);
        report();
    end
endmodule